// File: doc/BRIEF.md
# Dual-Direction Timer-Overflow Baud Tick Generator

This block produces the 16x oversampling ticks for a serial port's transmitter and receiver. It contains one narrow 8-bit auto-reload timer and several wide 16-bit auto-reload timers. The default is three wide timers. All of them run continuously. Each overflow of a timer is a one-cycle pulse, and each direction takes the pulses of the timer that its own select field names. The transmit rate and the receive rate can therefore come from different timers at the same time.

The narrow timer is advanced either by every system clock or by a divide-by-12 enable. Its overflows are halved to form the 16x tick, unless the double-rate control is set. A wide timer's overflow is used directly as the tick. A timer reloaded with value `r` overflows once every `2^W - r` timer clocks, where `W` is the timer width. All counters leave reset at all-ones, so each timer overflows on its first enabled cycle.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst_ni` is low, `tx_tick_o` and `rx_tick_o` are both 0.
- R2: With select code k (1 to 3), the tick period in system clocks is 65536 minus reload word k-1 of `reload_wide_i` (word 0 occupies bits 15:0).
- R3: With select code 0, `fast_clk_i`=1 and `double_i`=0, the tick period is 2*(256 - `reload_narrow_i`).
- R4: With select code 0, `fast_clk_i`=1 and `double_i`=1, the tick period is 256 - `reload_narrow_i`.
- R5: With select code 0 and `fast_clk_i`=0, the narrow timer advances once per 12 system clocks, so the periods of R3 and R4 are multiplied by 12.
- R6: `tx_sel_i` and `rx_sel_i` act independently. Different codes give each output its own period at the same time.
- R7: After a select field changes, the output only carries ticks from the newly selected source. When both fields hold the same code, the two outputs pulse in the same cycles.
- R8: Narrow reload 255 with `fast_clk_i`=1 and `double_i`=1 gives a tick on every cycle.
- R9: Wide reload 0xFFFF gives a tick on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fast_clk_i | input | 1 | 1: narrow timer advances every clock; 0: once per 12 clocks |
| double_i | input | 1 | 1: narrow overflow used directly; 0: halved |
| reload_narrow_i | input | 8 | Reload value of the narrow timer |
| reload_wide_i | input | 3x16 | Reload values of the wide timers, word k for timer k |
| tx_sel_i | input | 2 | Transmit tick source: 0 narrow, 1..3 wide timer 0..2 |
| rx_sel_i | input | 2 | Receive tick source, same coding |
| tx_tick_o | output | 1 | Transmit 16x tick pulse |
| rx_tick_o | output | 1 | Receive 16x tick pulse |

## Verification
The hardest condition to bring about from the ports is a select change in the middle of a running count, where a stale or extra pulse could leak out. The bench first drives the transmit field and the receive field to different wide timers with unrelated periods. It then moves the transmit field onto the receive field's timer. From the next edge onward, every transmit pulse must coincide with a receive pulse, and any lone transmit pulse counts as a glitch. The period sweeps discard two ticks after each reconfiguration, so that a reload written while a count is in progress does not disturb the measured intervals.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned NARROW_W = 8;
  localparam int unsigned WIDE_W   = 16;
  localparam int unsigned PRE_DIV  = 12;
  // select code of the narrow path; wide timer k uses code k+1
  localparam int unsigned SRC_NARROW = 0;
endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int unsigned DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic en_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign en_o = (cnt_q == LAST);
endmodule

// File: rtl/reload_timer.sv
module reload_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] reload_i,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;
  logic         ovf_q;
  logic         at_top;

  assign at_top = (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= en_i && at_top;
      if (en_i) cnt_q <= at_top ? reload_i : cnt_q + 1'b1;
    end
  end

  assign ovf_o = ovf_q;
endmodule

// File: rtl/tick_select.sv
module tick_select #(
  parameter int unsigned N_SRC = 4,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic tick_d, tick_q;

  // pulses are one cycle wide, so a per-cycle pick cannot slice one
  always_comb begin
    tick_d = 1'b0;
    for (int i = 0; i < int'(N_SRC); i++)
      if (int'(sel_i) == i) tick_d = src_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= tick_d;
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int unsigned N_WIDE = 3,
  parameter int unsigned NW     = NARROW_W,
  parameter int unsigned WW     = WIDE_W,
  parameter int unsigned DIV    = PRE_DIV
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       fast_clk_i,
  input  logic                       double_i,
  input  logic [NW-1:0]              reload_narrow_i,
  input  logic [N_WIDE-1:0][WW-1:0]  reload_wide_i,
  input  logic [$clog2(N_WIDE+1)-1:0] tx_sel_i,
  input  logic [$clog2(N_WIDE+1)-1:0] rx_sel_i,
  output logic                       tx_tick_o,
  output logic                       rx_tick_o
);
  localparam int unsigned N_SRC = N_WIDE + 1;
  localparam int unsigned SEL_W = $clog2(N_SRC);

  logic             pre_en;
  logic             en_narrow;
  logic             ovf8_w;
  logic             half_q;
  logic             tick8_w;
  logic [N_SRC-1:0] src_w;

  baud_prescaler #(.DIV(DIV)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_o  (pre_en)
  );

  assign en_narrow = fast_clk_i | pre_en;

  reload_timer #(.W(NW)) u_narrow (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_narrow),
    .reload_i(reload_narrow_i),
    .ovf_o   (ovf8_w)
  );

  // halving toggle runs on every narrow overflow whatever double_i is
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     half_q <= 1'b0;
    else if (ovf8_w) half_q <= ~half_q;
  end

  assign tick8_w = double_i ? ovf8_w : (ovf8_w & half_q);
  assign src_w[SRC_NARROW] = tick8_w;

  for (genvar k = 0; k < int'(N_WIDE); k++) begin : g_wide
    reload_timer #(.W(WW)) u_wide (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (1'b1),
      .reload_i(reload_wide_i[k]),
      .ovf_o   (src_w[k+1])
    );
  end

  tick_select #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_tx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .src_i (src_w),
    .sel_i (tx_sel_i),
    .tick_o(tx_tick_o)
  );

  tick_select #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_rx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .src_i (src_w),
    .sel_i (rx_sel_i),
    .tick_o(rx_tick_o)
  );
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int unsigned N_SRC = 4,
  parameter int unsigned SEL_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] src_i,
  input logic             ovf8_i,
  input logic             pre_sel_i,
  input logic [SEL_W-1:0] tx_sel_i,
  input logic [SEL_W-1:0] rx_sel_i,
  input logic             tx_tick_i,
  input logic             rx_tick_i
);
  logic started_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  // R6
  tx_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !started_q)
    tx_tick_i == $past(src_i[tx_sel_i]));

  // R6
  rx_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !started_q)
    rx_tick_i == $past(src_i[rx_sel_i]));

  // R5
  slow_narrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf8_i && !pre_sel_i) |=> !ovf8_i);

  // R7
  same_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !started_q)
    ($past(tx_sel_i) == $past(rx_sel_i)) |-> (tx_tick_i == rx_tick_i));

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!tx_tick_i && !rx_tick_i));
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.N_SRC(4), .SEL_W(2)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .src_i    (src_w),
  .ovf8_i   (ovf8_w),
  .pre_sel_i(fast_clk_i),
  .tx_sel_i (tx_sel_i),
  .rx_sel_i (rx_sel_i),
  .tx_tick_i(tx_tick_o),
  .rx_tick_i(rx_tick_o)
);

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             fast_clk_i = 1'b1;
  logic             double_i = 1'b0;
  logic [7:0]       reload_narrow_i = 8'd250;
  logic [2:0][15:0] reload_wide_i;
  logic [1:0]       tx_sel_i = 2'd0;
  logic [1:0]       rx_sel_i = 2'd1;
  logic             tx_tick_o, rx_tick_o;

  int n_cmp = 0;
  int n_bad = 0;
  int rel [3] = '{65530, 65520, 65500};
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  baud_tick_gen uut (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .fast_clk_i     (fast_clk_i),
    .double_i       (double_i),
    .reload_narrow_i(reload_narrow_i),
    .reload_wide_i  (reload_wide_i),
    .tx_sel_i       (tx_sel_i),
    .rx_sel_i       (rx_sel_i),
    .tx_tick_o      (tx_tick_o),
    .rx_tick_o      (rx_tick_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(input bit tx, output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!(tx ? tx_tick_o : rx_tick_o));
  endtask

  task automatic measure(input bit tx, input int exp, input string req);
    int c;
    wait_tick(tx, c);
    wait_tick(tx, c);
    for (int i = 0; i < 3; i++) begin
      wait_tick(tx, c);
      check(c == exp, req, c, exp);
    end
  endtask

  task automatic set_wide();
    for (int k = 0; k < 3; k++) reload_wide_i[k] = 16'(rel[k]);
  endtask

  initial begin
    int r8 [4] = '{255, 254, 250, 240};
    set_wide();
    repeat (4) begin
      @(negedge clk);
      check(!tx_tick_o && !rx_tick_o, "R1", {tx_tick_o, rx_tick_o}, 0);
    end
    rst_ni = 1'b1;

    // narrow path sweep, rx held on wide timer 0
    for (int ri = 0; ri < 4; ri++)
      for (int pre = 0; pre < 2; pre++)
        for (int dbl = 0; dbl < 2; dbl++) begin
          int exp;
          string tag;
          @(negedge clk);
          reload_narrow_i = 8'(r8[ri]);
          fast_clk_i = pre[0];
          double_i = dbl[0];
          tx_sel_i = 2'd0;
          rx_sel_i = 2'd1;
          exp = (pre == 1 ? 1 : 12) * (256 - r8[ri]) * (dbl == 1 ? 1 : 2);
          if (pre == 0) tag = "R5";
          else if (dbl == 1) tag = (r8[ri] == 255) ? "R8" : "R4";
          else tag = "R3";
          measure(1'b1, exp, tag);
          measure(1'b0, 65536 - rel[0], "R6");
        end

    // wide timers sweep, rx on a different wide timer
    for (int k = 0; k < 3; k++) begin
      int rv [4] = '{65535, 65534, 65520, 65500};
      for (int vi = 0; vi < 4; vi++) begin
        int j;
        j = (k + 1) % 3;
        @(negedge clk);
        rel[k] = rv[vi];
        set_wide();
        tx_sel_i = 2'(k + 1);
        rx_sel_i = 2'(j + 1);
        measure(1'b1, 65536 - rel[k], (rv[vi] == 65535) ? "R9" : "R2");
        measure(1'b0, 65536 - rel[j], "R6");
      end
    end

    // select change glitch test
    @(negedge clk);
    rel[0] = 65530; rel[1] = 65500; rel[2] = 65523;
    set_wide();
    tx_sel_i = 2'd1;
    rx_sel_i = 2'd3;
    repeat (100) @(negedge clk);
    begin
      int lone = 0;
      int seen = 0;
      tx_sel_i = 2'd3;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (tx_tick_o && !rx_tick_o) lone++;
        if (tx_tick_o != rx_tick_o) lone++;
        if (tx_tick_o) seen++;
      end
      check(lone == 0, "R7", lone, 0);
      check(seen == 200 / 13 || seen == 200 / 13 + 1, "R7", seen, 200 / 13);
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected completion", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule